// File: doc/BRIEF.md
# Address Translation Cache with Global-Entry Retention

This block holds recently used virtual-to-physical page translations for a 32-bit address space. It has sixteen fully associative slots, and each slot maps either one 4 KB page or one 4 MB large page. A requester presents a virtual address together with the access kind (read or write) and the privilege of the access (user or supervisor). One clock later the block reports exactly one of three outcomes:

- a hit, with the translated physical address;
- a miss;
- a permission fault, with the faulting address latched on a separate output so it can feed a page-fault address register.

An external table walker installs translations through a fill port. Three maintenance commands remove entries:

- a single-page invalidate;
- a flush that follows a reload of the page-table base register, which spares entries marked global;
- a full flush that follows a change of the global-page enable, which removes every entry.

Slots carry no address-space tag, so software must use these commands on every context change.

Top module: `xlat_cache`

## Requirements
- R1: A lookup asserted in one cycle yields `rsp_valid` in the next cycle with exactly one of `rsp_hit`, `rsp_miss`, `rsp_fault`. On a hit to a 4 KB entry, `rsp_paddr` = {stored frame[19:0], vaddr[11:0]}.
- R2: An entry installed with `fill_large`=1 matches any address whose bits [31:22] equal bits [19:10] of the stored page number. A hit gives `rsp_paddr` = {frame[19:10], vaddr[21:0]}.
- R3: A fill with `fill_present`=0 installs nothing, so later lookups of that page miss.
- R4: `inv_page` removes every entry that covers `inv_vaddr`, whether the entry is 4 KB or 4 MB.
- R5: `inv_base_reload` removes all entries with the global bit clear and keeps entries with the global bit set.
- R6: `inv_global_chg` removes all entries, global ones included.
- R7: A hit becomes a fault in three cases: a user access to an entry whose user bit is clear; a user write to an entry whose writable bit is clear; a supervisor write to an entry whose writable bit is clear while `wp_enable`=1. A supervisor write to a read-only entry with `wp_enable`=0 hits.
- R8: On a fault, `fault_vaddr` shows the faulting virtual address in the same cycle as `rsp_fault`. It holds that value until the next fault.
- R9: When several valid entries match, the lowest-index entry supplies the result.
- R10: A present fill goes into the lowest-index free slot. If no slot is free, it replaces the slot named by a round-robin pointer. The pointer starts at 0 after reset and advances by one, modulo 16, after each such replacement.
- R11: When several commands arrive in the same cycle, only one takes effect, in this order of priority: `inv_global_chg`, then `inv_base_reload`, then `inv_page`, then fill. A lookup in a cycle always sees the table as it was before that cycle's command.
- R12: After reset every slot is empty: `rsp_valid` is 0 and any lookup misses.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| lk_valid | input | 1 | Lookup request |
| lk_vaddr | input | 32 | Lookup virtual address |
| lk_write | input | 1 | 1 = write access |
| lk_user | input | 1 | 1 = user-mode access |
| wp_enable | input | 1 | Write protection also applies to supervisor writes |
| fill_valid | input | 1 | Install request |
| fill_vpn | input | 20 | Virtual page number to install |
| fill_pfn | input | 20 | Physical frame number |
| fill_large | input | 1 | Entry maps a 4 MB page |
| fill_global | input | 1 | Entry survives base reload |
| fill_user | input | 1 | User access allowed |
| fill_write | input | 1 | Writes allowed |
| fill_present | input | 1 | Translation present |
| inv_page | input | 1 | Invalidate entries covering inv_vaddr |
| inv_vaddr | input | 32 | Address for single-page invalidate |
| inv_base_reload | input | 1 | Drop non-global entries |
| inv_global_chg | input | 1 | Drop all entries |
| rsp_valid | output | 1 | Response present |
| rsp_hit | output | 1 | Translation succeeded |
| rsp_miss | output | 1 | No matching entry |
| rsp_fault | output | 1 | Permission fault |
| rsp_paddr | output | 32 | Physical address on hit |
| fault_vaddr | output | 32 | Last faulting virtual address |

## Verification
A corrupted slot (wrong page number, a valid bit left set, or a global bit lost) shows up at the ports on the first lookup of an affected address, one cycle after the request. It appears as a wrong `rsp_paddr`, or as a hit where a miss is due, or the reverse. A drifting replacement pointer shows only after the table fills, when the page that should have been evicted still hits. A wrong permission decode flips hit into fault one cycle after the offending access, and the same cycle also exposes a stale `fault_vaddr`.

// File: rtl/xc_pkg.sv
package xc_pkg;
    localparam int VA_W     = 32;
    localparam int OFS_W    = 12;
    localparam int LG_OFS_W = 22;
    localparam int VPN_W    = VA_W - OFS_W;
    localparam int LTAG_W   = VA_W - LG_OFS_W;

    typedef struct packed {
        logic             vld;
        logic             lrg;
        logic             glb;
        logic             usr;
        logic             wr;
        logic [VPN_W-1:0] vpn;
        logic [VPN_W-1:0] pfn;
    } xc_entry_t;
endpackage

// File: rtl/xc_entry_cmp.sv
module xc_entry_cmp
    import xc_pkg::*;
(
    input  xc_entry_t        ent_i,
    input  logic [VA_W-1:0]  lk_va_i,
    input  logic [VA_W-1:0]  inv_va_i,
    output logic             lk_hit_o,
    output logic             inv_hit_o
);
    function automatic logic covers(input xc_entry_t e, input logic [VA_W-1:0] va);
        if (!e.vld) return 1'b0;
        if (e.lrg)  return e.vpn[VPN_W-1 -: LTAG_W] == va[VA_W-1 -: LTAG_W];
        return e.vpn == va[VA_W-1:OFS_W];
    endfunction

    always_comb begin
        lk_hit_o  = covers(ent_i, lk_va_i);
        inv_hit_o = covers(ent_i, inv_va_i);
    end
endmodule

// File: rtl/xc_first_one.sv
module xc_first_one #(
    parameter int N  = 16,
    localparam int IW = (N > 1) ? $clog2(N) : 1
) (
    input  logic [N-1:0]  req_i,
    output logic          found_o,
    output logic [IW-1:0] idx_o
);
    always_comb begin
        found_o = |req_i;
        idx_o   = '0;
        for (int i = N - 1; i >= 0; i--) begin
            if (req_i[i]) idx_o = i[IW-1:0];
        end
    end
endmodule

// File: rtl/xlat_cache.sv
module xlat_cache
    import xc_pkg::*;
#(
    parameter int ENTRIES = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             lk_valid,
    input  logic [VA_W-1:0]  lk_vaddr,
    input  logic             lk_write,
    input  logic             lk_user,
    input  logic             wp_enable,
    input  logic             fill_valid,
    input  logic [VPN_W-1:0] fill_vpn,
    input  logic [VPN_W-1:0] fill_pfn,
    input  logic             fill_large,
    input  logic             fill_global,
    input  logic             fill_user,
    input  logic             fill_write,
    input  logic             fill_present,
    input  logic             inv_page,
    input  logic [VA_W-1:0]  inv_vaddr,
    input  logic             inv_base_reload,
    input  logic             inv_global_chg,
    output logic             rsp_valid,
    output logic             rsp_hit,
    output logic             rsp_miss,
    output logic             rsp_fault,
    output logic [VA_W-1:0]  rsp_paddr,
    output logic [VA_W-1:0]  fault_vaddr
);
    localparam int IDX_W = (ENTRIES > 1) ? $clog2(ENTRIES) : 1;
    localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(ENTRIES - 1);

    typedef struct packed {
        xc_entry_t [ENTRIES-1:0] tab;
        logic [IDX_W-1:0]        ptr;
        logic                    rsp_v;
        logic                    hit;
        logic                    miss;
        logic                    flt;
        logic [VA_W-1:0]         pa;
        logic [VA_W-1:0]         flt_va;
    } state_t;

    state_t s_d, s_q;

    logic [ENTRIES-1:0] lk_hit_vec, inv_hit_vec, vld_vec, glb_vec;
    logic               lk_found, free_found;
    logic [IDX_W-1:0]   lk_idx, free_idx;

    // One comparator pair per slot
    for (genvar g = 0; g < ENTRIES; g++) begin : g_cmp
        xc_entry_cmp u_cmp (
            .ent_i     (s_q.tab[g]),
            .lk_va_i   (lk_vaddr),
            .inv_va_i  (inv_vaddr),
            .lk_hit_o  (lk_hit_vec[g]),
            .inv_hit_o (inv_hit_vec[g])
        );
    end

    always_comb begin
        for (int i = 0; i < ENTRIES; i++) begin
            vld_vec[i] = s_q.tab[i].vld;
            glb_vec[i] = s_q.tab[i].glb;
        end
    end

    // Lowest index wins among matches
    xc_first_one #(.N(ENTRIES)) u_lk_pick (
        .req_i   (lk_hit_vec),
        .found_o (lk_found),
        .idx_o   (lk_idx)
    );

    // Lowest free slot for fills
    xc_first_one #(.N(ENTRIES)) u_free_pick (
        .req_i   (~vld_vec),
        .found_o (free_found),
        .idx_o   (free_idx)
    );

    xc_entry_t sel, new_ent;
    logic      deny;

    always_comb begin
        s_d = s_q;

        sel  = s_q.tab[lk_idx];
        deny = (lk_user && !sel.usr) ||
               (lk_write && !sel.wr && (lk_user || wp_enable));

        s_d.rsp_v = lk_valid;
        s_d.hit   = 1'b0;
        s_d.miss  = 1'b0;
        s_d.flt   = 1'b0;
        if (lk_valid) begin
            if (!lk_found) begin
                s_d.miss = 1'b1;
            end else if (deny) begin
                s_d.flt    = 1'b1;
                s_d.flt_va = lk_vaddr;
            end else begin
                s_d.hit = 1'b1;
                s_d.pa  = sel.lrg ? {sel.pfn[VPN_W-1 -: LTAG_W], lk_vaddr[LG_OFS_W-1:0]}
                                  : {sel.pfn, lk_vaddr[OFS_W-1:0]};
            end
        end

        new_ent.vld = 1'b1;
        new_ent.lrg = fill_large;
        new_ent.glb = fill_global;
        new_ent.usr = fill_user;
        new_ent.wr  = fill_write;
        new_ent.vpn = fill_vpn;
        new_ent.pfn = fill_pfn;

        if (inv_global_chg) begin
            for (int i = 0; i < ENTRIES; i++) s_d.tab[i].vld = 1'b0;
        end else if (inv_base_reload) begin
            for (int i = 0; i < ENTRIES; i++)
                if (!s_q.tab[i].glb) s_d.tab[i].vld = 1'b0;
        end else if (inv_page) begin
            for (int i = 0; i < ENTRIES; i++)
                if (inv_hit_vec[i]) s_d.tab[i].vld = 1'b0;
        end else if (fill_valid && fill_present) begin
            if (free_found) begin
                s_d.tab[free_idx] = new_ent;
            end else begin
                s_d.tab[s_q.ptr] = new_ent;
                s_d.ptr = (s_q.ptr == LAST_IDX) ? '0 : s_q.ptr + 1'b1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign rsp_valid   = s_q.rsp_v;
    assign rsp_hit     = s_q.hit;
    assign rsp_miss    = s_q.miss;
    assign rsp_fault   = s_q.flt;
    assign rsp_paddr   = s_q.pa;
    assign fault_vaddr = s_q.flt_va;

    // R1: one response per request, one outcome
    assert_rsp_follows_req_R1: assert property (@(posedge clk) disable iff (!rst_n)
        lk_valid |=> rsp_valid);
    assert_single_outcome_R1: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |-> $countones({rsp_hit, rsp_miss, rsp_fault}) == 1);
    // R3: non-present fill leaves table untouched
    assert_no_nonpresent_fill_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (fill_valid && !fill_present && !inv_page && !inv_base_reload && !inv_global_chg)
        |=> $stable(vld_vec));
    // R4: covering entries gone after page invalidate
    assert_page_inv_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (inv_page && !inv_base_reload && !inv_global_chg)
        |=> (vld_vec & $past(inv_hit_vec)) == '0);
    // R5: reload clears non-global, keeps global
    assert_reload_clear_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (inv_base_reload && !inv_global_chg) |=> (vld_vec & ~glb_vec) == '0);
    assert_reload_keep_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (inv_base_reload && !inv_global_chg) |=> (vld_vec & glb_vec) == $past(vld_vec & glb_vec));
    // R6: global-enable change empties table
    assert_global_flush_R6: assert property (@(posedge clk) disable iff (!rst_n)
        inv_global_chg |=> vld_vec == '0);
    // R8: fault address tracks the faulting request
    assert_fault_addr_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (lk_valid ##1 rsp_fault) |-> fault_vaddr == $past(lk_vaddr));
endmodule

// File: tb/xlat_cache_tb_top.sv
module xlat_cache_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        lk_valid = 0, lk_write = 0, lk_user = 0, wp_enable = 0;
    logic [31:0] lk_vaddr = '0, inv_vaddr = '0;
    logic        fill_valid = 0, fill_large = 0, fill_global = 0, fill_user = 0;
    logic        fill_write = 0, fill_present = 0;
    logic [19:0] fill_vpn = '0, fill_pfn = '0;
    logic        inv_page = 0, inv_base_reload = 0, inv_global_chg = 0;
    logic        rsp_valid, rsp_hit, rsp_miss, rsp_fault;
    logic [31:0] rsp_paddr, fault_vaddr;

    always #10 clk = ~clk;

    xlat_cache dut_i (
        .clk(clk), .rst_n(rst_n), .lk_valid(lk_valid), .lk_vaddr(lk_vaddr),
        .lk_write(lk_write), .lk_user(lk_user), .wp_enable(wp_enable),
        .fill_valid(fill_valid), .fill_vpn(fill_vpn), .fill_pfn(fill_pfn),
        .fill_large(fill_large), .fill_global(fill_global), .fill_user(fill_user),
        .fill_write(fill_write), .fill_present(fill_present), .inv_page(inv_page),
        .inv_vaddr(inv_vaddr), .inv_base_reload(inv_base_reload),
        .inv_global_chg(inv_global_chg), .rsp_valid(rsp_valid), .rsp_hit(rsp_hit),
        .rsp_miss(rsp_miss), .rsp_fault(rsp_fault), .rsp_paddr(rsp_paddr),
        .fault_vaddr(fault_vaddr)
    );

    int unsigned n_chk = 0, n_bad = 0;

    // Reference table
    bit        m_v[16], m_lg[16], m_g[16], m_u[16], m_w[16];
    bit [19:0] m_vpn[16], m_pfn[16];
    bit [3:0]  m_ptr = 0;

    function automatic bit m_cover(int i, logic [31:0] va);
        if (!m_v[i]) return 0;
        if (m_lg[i]) return m_vpn[i][19:10] == va[31:22];
        return m_vpn[i] == va[31:12];
    endfunction

    task automatic chk(input bit ok, input string tag, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
        end
    endtask

    task automatic idle();
        lk_valid = 0; lk_write = 0; lk_user = 0;
        fill_valid = 0; inv_page = 0; inv_base_reload = 0; inv_global_chg = 0;
    endtask

    // Compute expectation, update model, advance one cycle, compare
    task automatic tick(input string tag);
        bit e_hit, e_miss, e_flt, found;
        bit [31:0] e_pa;
        int k;
        e_hit = 0; e_miss = 0; e_flt = 0; e_pa = '0; found = 0; k = 0;
        if (lk_valid) begin
            for (int i = 0; i < 16; i++)
                if (!found && m_cover(i, lk_vaddr)) begin found = 1; k = i; end
            if (!found) e_miss = 1;
            else if ((lk_user && !m_u[k]) ||
                     (lk_write && !m_w[k] && (lk_user || wp_enable))) e_flt = 1;
            else begin
                e_hit = 1;
                e_pa = m_lg[k] ? {m_pfn[k][19:10], lk_vaddr[21:0]}
                               : {m_pfn[k], lk_vaddr[11:0]};
            end
        end
        if (inv_global_chg) begin
            for (int i = 0; i < 16; i++) m_v[i] = 0;
        end else if (inv_base_reload) begin
            for (int i = 0; i < 16; i++) if (!m_g[i]) m_v[i] = 0;
        end else if (inv_page) begin
            for (int i = 0; i < 16; i++) if (m_cover(i, inv_vaddr)) m_v[i] = 0;
        end else if (fill_valid && fill_present) begin
            int slot;
            slot = -1;
            for (int i = 15; i >= 0; i--) if (!m_v[i]) slot = i;
            if (slot < 0) begin slot = int'(m_ptr); m_ptr = m_ptr + 1; end
            m_v[slot] = 1; m_lg[slot] = fill_large; m_g[slot] = fill_global;
            m_u[slot] = fill_user; m_w[slot] = fill_write;
            m_vpn[slot] = fill_vpn; m_pfn[slot] = fill_pfn;
        end
        @(posedge clk);
        @(negedge clk);
        if (lk_valid) begin
            chk(rsp_valid === 1'b1, tag, "rsp_valid", {31'b0, rsp_valid}, 32'd1);
            chk({rsp_hit, rsp_miss, rsp_fault} === {e_hit, e_miss, e_flt}, tag, "outcome",
                {29'b0, rsp_hit, rsp_miss, rsp_fault}, {29'b0, e_hit, e_miss, e_flt});
            if (e_hit) chk(rsp_paddr === e_pa, tag, "paddr", rsp_paddr, e_pa);
            if (e_flt) chk(fault_vaddr === lk_vaddr, tag, "fault_vaddr", fault_vaddr, lk_vaddr);
        end
        idle();
    endtask

    task automatic do_fill(input logic [31:0] va, input logic [19:0] pfn, input bit lg,
                           input bit gl, input bit us, input bit wr, input bit pr,
                           input string tag);
        fill_valid = 1; fill_vpn = va[31:12]; fill_pfn = pfn; fill_large = lg;
        fill_global = gl; fill_user = us; fill_write = wr; fill_present = pr;
        tick(tag);
    endtask

    task automatic do_look(input logic [31:0] va, input bit wr, input bit us, input string tag);
        lk_valid = 1; lk_vaddr = va; lk_write = wr; lk_user = us;
        tick(tag);
    endtask

    function automatic logic [31:0] pool_va();
        logic [9:0] up, mid;
        case ($urandom % 4)
            0: up = 10'h001; 1: up = 10'h002; 2: up = 10'h200; default: up = 10'h3FF;
        endcase
        case ($urandom % 4)
            0: mid = 10'h000; 1: mid = 10'h001; 2: mid = 10'h155; default: mid = 10'h3FF;
        endcase
        return {up, mid, 12'($urandom)};
    endfunction

    initial begin
        repeat (200000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog expired");
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        void'($urandom(32'h5EED_1234));
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        // R12: empty after reset
        chk(rsp_valid === 1'b0, "R12", "rsp_valid", {31'b0, rsp_valid}, 32'd0);
        do_look(32'h0040_3ABC, 0, 0, "R12");

        // R1: 4 KB translation
        do_fill(32'h0040_3000, 20'h12345, 0, 0, 1, 1, 1, "R1");
        do_look(32'h0040_3ABC, 0, 1, "R1");
        do_look(32'h0040_4ABC, 0, 1, "R1");
        // R2: large page
        do_fill(32'h8040_0000, 20'hABC00, 1, 0, 1, 1, 1, "R2");
        do_look(32'h807F_1234, 1, 1, "R2");
        do_look(32'h8080_0000, 0, 1, "R2");
        // R3: non-present fill ignored
        do_fill(32'h1000_0000, 20'h00777, 0, 0, 1, 1, 0, "R3");
        do_look(32'h1000_0010, 0, 0, "R3");
        // R7, R8: permissions and fault address
        do_fill(32'h2000_0000, 20'h0BEEF, 0, 0, 0, 0, 1, "R7");
        do_look(32'h2000_0123, 0, 1, "R7 R8");
        do_look(32'h2000_0456, 1, 0, "R7");
        wp_enable = 1;
        do_look(32'h2000_0789, 1, 0, "R7 R8");
        wp_enable = 0;
        do_look(32'h2000_0ABC, 0, 0, "R7");
        do_fill(32'h2100_0000, 20'h0CAFE, 0, 0, 1, 0, 1, "R7");
        do_look(32'h2100_0FFF, 1, 1, "R7 R8");
        // R9: duplicates, lowest index wins; R4 removes both
        do_fill(32'h3000_5000, 20'h11111, 0, 0, 1, 1, 1, "R9");
        do_fill(32'h3000_5000, 20'h22222, 0, 0, 1, 1, 1, "R9");
        do_look(32'h3000_5004, 0, 0, "R9");
        inv_page = 1; inv_vaddr = 32'h3000_5FFF; tick("R4");
        do_look(32'h3000_5004, 0, 0, "R4");
        // R4: large entry removed via inner address
        inv_page = 1; inv_vaddr = 32'h8055_0000; tick("R4");
        do_look(32'h807F_1234, 0, 1, "R4");
        // R5: reload keeps global
        do_fill(32'h4000_0000, 20'h00444, 0, 1, 1, 1, 1, "R5");
        do_look(32'h4000_0008, 0, 0, "R5");
        inv_base_reload = 1; tick("R5");
        do_look(32'h4000_0008, 0, 0, "R5");
        do_look(32'h0040_3ABC, 0, 1, "R5");
        // R11: reload and fill in the same cycle, fill dropped
        inv_base_reload = 1; fill_valid = 1; fill_vpn = 20'h50000; fill_pfn = 20'h1;
        fill_present = 1; fill_large = 0; fill_global = 1; tick("R11");
        do_look(32'h5000_0000, 0, 0, "R11");
        // R6: global change removes everything
        inv_global_chg = 1; inv_page = 1; inv_vaddr = 32'h0; tick("R6 R11");
        do_look(32'h4000_0008, 0, 0, "R6");
        // R10: replacement order
        for (int i = 0; i < 17; i++)
            do_fill({10'h005, 10'(i), 12'h0}, 20'(i + 16'h100), 0, 0, 1, 1, 1, "R10");
        do_look({10'h005, 10'd0, 12'h010}, 0, 0, "R10");
        do_look({10'h005, 10'd1, 12'h010}, 0, 0, "R10");
        do_look({10'h005, 10'd16, 12'h010}, 0, 0, "R10");
        do_fill({10'h005, 10'd17, 12'h0}, 20'h00999, 0, 0, 1, 1, 1, "R10");
        do_look({10'h005, 10'd1, 12'h010}, 0, 0, "R10");
        do_look({10'h005, 10'd17, 12'h010}, 0, 0, "R10");

        // Random mix: R1 R2 R4 R5 R6 R7 R9 R10 R11
        for (int n = 0; n < 4000; n++) begin
            int r;
            r = $urandom % 100;
            if ($urandom % 20 == 0) wp_enable = ~wp_enable;
            if ($urandom % 100 < 70) begin
                lk_valid = 1; lk_vaddr = pool_va();
                lk_write = 1'($urandom); lk_user = 1'($urandom);
            end
            if (r < 1) inv_global_chg = 1;
            else if (r < 3) inv_base_reload = 1;
            else if (r < 9) begin inv_page = 1; inv_vaddr = pool_va(); end
            if (r >= 5 && r < 45) begin
                logic [31:0] va;
                va = pool_va();
                fill_valid = 1; fill_vpn = va[31:12]; fill_pfn = 20'($urandom);
                fill_large = ($urandom % 4 == 0); fill_global = ($urandom % 10 < 3);
                fill_user = 1'($urandom); fill_write = 1'($urandom);
                fill_present = ($urandom % 100 < 85);
            end
            tick("random R1 R2 R4 R5 R6 R7 R9 R10 R11");
        end

        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule